// File: doc/BRIEF.md
# Fragmented CAN Message Reassembler

This block sits behind a CAN receive path and turns a series of frames that belong to one message object into a single contiguous message in a byte buffer. Each frame arrives as a one-cycle strobe together with its data length code and up to eight data bytes. The first data byte is read as a transport-layer fragmentation header. The remaining bytes are user data. They are written to the buffer through a lane-masked write port, one frame per cycle, at the offset where the previous frame stopped.

Three header formats can be selected. The first is DeviceNet-style I/O fragmentation, which uses a fragment type and a fragment count. The second is the ISO-TP/OSEK consecutive-frame form, which uses a 4-bit sequence number. The third is the CANopen domain-segment form, which uses a toggle bit and a last-segment bit. The block checks that the fragments arrive in the expected order. It signals message complete, with the total byte count, only when the final frame has been stored. A broken sequence, a bad header, or a message longer than 255 bytes discards the partial message and produces a one-cycle error pulse.

Top module: `frag_reasm`

## Requirements
- R1: `frm_data[7:0]` is the header byte and `frm_data[8*k+7:8*k]` is user byte k (k = 1..DLC-1). A DLC above 8 counts as 8, and a DLC of 0 is an error. All outputs are registered and reflect a frame one cycle after `frm_valid`. With no `frm_valid`, the next cycle has `wr_en`, `msg_done` and `frag_err` low.
- R2: For an accepted frame that carries L > 0 user bytes, `wr_en` pulses. `wr_mask` then has its low L bits set, lane i of `wr_lanes` carries user byte i+1 for offset `wr_base`+i, and `wr_base` equals the bytes already stored for the message (0 for an opening frame). When `wr_en` is low, `wr_base`, `wr_mask` and `wr_lanes` are zero.
- R3: `cfg_mode` selects the header format: 0 = fragment type/count, 1 = consecutive frame, 2 = toggle segment, 3 = reserved. In reserved mode every frame is an error.
- R4: In mode 0 the type is header bits 7:6 and the count is bits 5:0. Type 00 with count 0 opens a message, and type 00 with count 3Fh is a complete one-frame message. Type 01 is a middle fragment and type 10 is the final one. Type 11, or type 00 with any other count, is an error.
- R5: In mode 0 the fragment after the opener must carry count 1. Each further middle or final fragment must carry the previous count plus one, modulo 64. A mismatch, or a middle or final fragment with no message open, is an error.
- R6: In mode 0 an opening fragment that arrives while a message is open discards it and restarts at offset 0.
- R7: In mode 1 the header high nibble must be 0010b and the sequence number is bits 3:0. A message opens with sequence number 1, and each later frame must carry the previous number plus one, modulo 16. A frame with DLC below 8 is the final one.
- R8: In mode 2 the toggle is header bit 4 and the last flag is bit 0. The first segment must carry toggle 0, and each later segment must carry the inverse of the previous toggle. A last flag of 1 ends the message.
- R9: `msg_done` pulses in the same cycle as the write of the final frame. `done_count` then shows the message's total byte count and holds it until the next completion. A message that would finish with 0 bytes is an error.
- R10: If accepting a frame would take the total beyond 255 bytes, the frame is not written, the message is discarded and `frag_err` pulses.
- R11: On any error, `frag_err` pulses for one cycle, nothing is written, `msg_done` stays low, and the partial message is discarded, so the next frame must open a new message.
- R12: After reset all outputs are zero and no message is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Header format select |
| frm_valid | input | 1 | One-cycle strobe, frame present |
| frm_dlc | input | 4 | Data length code of the frame |
| frm_data | input | 64 | Frame data bytes, byte 0 in bits 7:0 |
| wr_en | output | 1 | Buffer write strobe |
| wr_base | output | 8 | Buffer byte offset of lane 0 |
| wr_mask | output | 7 | Per-lane write enables |
| wr_lanes | output | 56 | Write data, lane i in bits 8i+7:8i |
| msg_done | output | 1 | Message complete pulse |
| frag_err | output | 1 | Fragment error pulse |
| done_count | output | 8 | Byte count of the last completed message |

## Verification
The assertions check several properties on every cycle: that complete and error never fire together, that an error never comes with a write, that the write mask is a contiguous run from lane 0, that no write reaches past offset 255, that a completion never reports zero bytes, and that reserved mode and idle cycles produce the expected outputs. Whether the sequence rules are enforced can only be seen in the bench scenarios. These cover count wrap modulo 64, sequence wrap modulo 16, toggle alternation, restart on a mid-message opener, the exact 255-byte boundary and its overflow, and DLC clamping. A behavioural reference model checks each of these cycle by cycle.

// File: rtl/frag_reasm_pkg.sv
package frag_reasm_pkg;

    localparam int FRAME_BYTES_DEF = 8;
    localparam int CNT_W_DEF       = 8;
    localparam int SEQ_W           = 6;

    typedef enum logic [1:0] {
        MODE_FRAGIO  = 2'd0,
        MODE_CONSEC  = 2'd1,
        MODE_SEGMENT = 2'd2,
        MODE_RSVD    = 2'd3
    } hdr_mode_e;

    typedef enum logic [2:0] {
        ACT_ERR    = 3'd0,
        ACT_START  = 3'd1,
        ACT_CONT   = 3'd2,
        ACT_LAST   = 3'd3,
        ACT_SINGLE = 3'd4
    } frag_act_e;

    typedef struct packed {
        frag_act_e        act;
        logic [SEQ_W-1:0] seq_nxt;
    } hdr_verdict_t;

    function automatic logic act_opens(frag_act_e a);
        return (a == ACT_START) || (a == ACT_SINGLE);
    endfunction

    function automatic logic act_closes(frag_act_e a);
        return (a == ACT_LAST) || (a == ACT_SINGLE);
    endfunction

endpackage

// File: rtl/frag_hdr_decode.sv
module frag_hdr_decode
    import frag_reasm_pkg::*;
(
    input  hdr_mode_e        mode,
    input  logic [7:0]       hdr,
    input  logic             last_short,
    input  logic             busy,
    input  logic [SEQ_W-1:0] seq_exp,
    output hdr_verdict_t     verdict
);

    logic [1:0] f_type;
    logic [5:0] f_cnt;
    logic [3:0] sn;
    logic       tgl;
    logic       tgl_exp;
    logic       seg_last;

    assign f_type   = hdr[7:6];
    assign f_cnt    = hdr[5:0];
    assign sn       = hdr[3:0];
    assign tgl      = hdr[4];
    assign seg_last = hdr[0];
    assign tgl_exp  = busy ? seq_exp[0] : 1'b0;

    always_comb begin
        verdict.act     = ACT_ERR;
        verdict.seq_nxt = '0;
        unique case (mode)
            MODE_FRAGIO: begin
                unique case (f_type)
                    2'b00: begin
                        if (f_cnt == 6'h3F) begin
                            verdict.act = ACT_SINGLE;
                        end else if (f_cnt == 6'h00) begin
                            verdict.act     = ACT_START;
                            verdict.seq_nxt = 6'd1;
                        end
                    end
                    2'b01: begin
                        if (busy && (f_cnt == seq_exp)) begin
                            verdict.act     = ACT_CONT;
                            verdict.seq_nxt = f_cnt + 6'd1;
                        end
                    end
                    2'b10: begin
                        if (busy && (f_cnt == seq_exp)) begin
                            verdict.act = ACT_LAST;
                        end
                    end
                    default: verdict.act = ACT_ERR;
                endcase
            end
            MODE_CONSEC: begin
                verdict.seq_nxt = {2'b00, sn + 4'd1};
                if (hdr[7:4] == 4'b0010) begin
                    if (!busy) begin
                        if (sn == 4'd1) begin
                            verdict.act = last_short ? ACT_SINGLE : ACT_START;
                        end
                    end else if (sn == seq_exp[3:0]) begin
                        verdict.act = last_short ? ACT_LAST : ACT_CONT;
                    end
                end
            end
            MODE_SEGMENT: begin
                verdict.seq_nxt = {5'b0, ~tgl};
                if (tgl == tgl_exp) begin
                    if (busy) begin
                        verdict.act = seg_last ? ACT_LAST : ACT_CONT;
                    end else begin
                        verdict.act = seg_last ? ACT_SINGLE : ACT_START;
                    end
                end
            end
            default: verdict.act = ACT_ERR;
        endcase
    end

endmodule

// File: rtl/frag_lane_pack.sv
module frag_lane_pack #(
    parameter int FRAME_BYTES = 8,
    localparam int LANES      = FRAME_BYTES - 1,
    localparam int LEN_W      = $clog2(FRAME_BYTES)
) (
    input  logic [8*FRAME_BYTES-1:0] frame,
    input  logic [LEN_W-1:0]         len,
    input  logic                     enable,
    output logic [LANES-1:0]         mask,
    output logic [8*LANES-1:0]       lanes
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic live;
        assign live              = enable && (LEN_W'(i) < len);
        assign mask[i]           = live;
        assign lanes[8*i +: 8]   = live ? frame[8*(i+1) +: 8] : 8'h00;
    end

endmodule

// File: rtl/frag_reasm.sv
module frag_reasm
    import frag_reasm_pkg::*;
#(
    parameter int FRAME_BYTES = FRAME_BYTES_DEF,
    parameter int CNT_W       = CNT_W_DEF,
    localparam int LANES      = FRAME_BYTES - 1,
    localparam int LEN_W      = $clog2(FRAME_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               cfg_mode,
    input  logic                     frm_valid,
    input  logic [3:0]               frm_dlc,
    input  logic [8*FRAME_BYTES-1:0] frm_data,
    output logic                     wr_en,
    output logic [CNT_W-1:0]         wr_base,
    output logic [LANES-1:0]         wr_mask,
    output logic [8*LANES-1:0]       wr_lanes,
    output logic                     msg_done,
    output logic                     frag_err,
    output logic [CNT_W-1:0]         done_count
);

    localparam logic [CNT_W:0] MAX_CNT = (CNT_W+1)'((1 << CNT_W) - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] fill;
        logic [SEQ_W-1:0] seq;
    } reasm_ctx_t;

    reasm_ctx_t   ctx_q;
    hdr_verdict_t verdict;

    logic [3:0]       dlc_eff;
    logic [LEN_W-1:0] len;
    logic             no_hdr;
    logic             opens;
    logic             closes;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   total;
    logic             bad;
    logic             take;
    logic             do_write;
    logic [LANES-1:0]   mask_n;
    logic [8*LANES-1:0] lanes_n;

    assign dlc_eff = (frm_dlc > 4'(FRAME_BYTES)) ? 4'(FRAME_BYTES) : frm_dlc;
    assign no_hdr  = (dlc_eff == 4'd0);
    assign len     = no_hdr ? '0 : LEN_W'(dlc_eff - 4'd1);

    frag_hdr_decode u_decode (
        .mode       (hdr_mode_e'(cfg_mode)),
        .hdr        (frm_data[7:0]),
        .last_short (dlc_eff < 4'(FRAME_BYTES)),
        .busy       (ctx_q.busy),
        .seq_exp    (ctx_q.seq),
        .verdict    (verdict)
    );

    assign opens  = act_opens(verdict.act);
    assign closes = act_closes(verdict.act);
    assign base   = opens ? '0 : ctx_q.fill;
    assign total  = {1'b0, base} + {{(CNT_W+1-LEN_W){1'b0}}, len};

    assign bad = no_hdr
              || (verdict.act == ACT_ERR)
              || (total > MAX_CNT)
              || (closes && (total == '0));

    assign take     = frm_valid && !bad;
    assign do_write = take && (len != '0);

    frag_lane_pack #(.FRAME_BYTES(FRAME_BYTES)) u_pack (
        .frame  (frm_data),
        .len    (len),
        .enable (do_write),
        .mask   (mask_n),
        .lanes  (lanes_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q      <= '0;
            wr_en      <= 1'b0;
            wr_base    <= '0;
            wr_mask    <= '0;
            wr_lanes   <= '0;
            msg_done   <= 1'b0;
            frag_err   <= 1'b0;
            done_count <= '0;
        end else begin
            wr_en    <= do_write;
            wr_base  <= do_write ? base : '0;
            wr_mask  <= mask_n;
            wr_lanes <= lanes_n;
            msg_done <= take && closes;
            frag_err <= frm_valid && bad;
            if (take && closes) begin
                done_count <= total[CNT_W-1:0];
            end
            if (frm_valid) begin
                if (bad || closes) begin
                    ctx_q <= '0;
                end else begin
                    ctx_q.busy <= 1'b1;
                    ctx_q.fill <= total[CNT_W-1:0];
                    ctx_q.seq  <= verdict.seq_nxt;
                end
            end
        end
    end

    // R1: an idle cycle leaves every event output low on the next cycle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> (!wr_en && !msg_done && !frag_err));

    // R2: write lanes always form a run starting at lane 0
    assert_mask_contig_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_mask[0] && ((wr_mask & (wr_mask + 1'b1)) == '0)));

    // R3: reserved mode rejects every frame
    assert_rsvd_mode_err_R3: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && (cfg_mode == 2'd3)) |=> frag_err);

    // R9: a completed message never reports zero bytes
    assert_done_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        msg_done |-> (done_count != '0));

    // R10: no write lane lands beyond the top of the byte range
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (({1'b0, wr_base} + (CNT_W+1)'($countones(wr_mask))) <= MAX_CNT));

    // R11: an error pulse excludes both a write and a completion
    assert_err_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        frag_err |-> (!wr_en && !msg_done));

endmodule

// File: tb/frag_reasm_tb_top.sv
module frag_reasm_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'd0;
    logic        frm_valid = 1'b0;
    logic [3:0]  frm_dlc = 4'd0;
    logic [63:0] frm_data = '0;
    logic        wr_en;
    logic [7:0]  wr_base;
    logic [6:0]  wr_mask;
    logic [55:0] wr_lanes;
    logic        msg_done;
    logic        frag_err;
    logic [7:0]  done_count;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    frag_reasm dut_i (
        .clk (clk), .rst (rst), .cfg_mode (cfg_mode),
        .frm_valid (frm_valid), .frm_dlc (frm_dlc), .frm_data (frm_data),
        .wr_en (wr_en), .wr_base (wr_base), .wr_mask (wr_mask),
        .wr_lanes (wr_lanes), .msg_done (msg_done), .frag_err (frag_err),
        .done_count (done_count)
    );

    // behavioural reference model
    int          m_open, m_fill, m_seq;
    logic        e_wr, e_done, e_err;
    logic [7:0]  e_base, e_cnt;
    logic [6:0]  e_mask;
    logic [55:0] e_lanes;

    always @(posedge clk) begin
        int n, len, kind, hdr, ty, ct, sn, tg, base, tot;
        logic [55:0] lb;
        if (rst) begin
            m_open = 0; m_fill = 0; m_seq = 0;
            e_wr <= 0; e_done <= 0; e_err <= 0; e_base <= 0; e_cnt <= 0;
            e_mask <= 0; e_lanes <= 0;
        end else if (!frm_valid) begin
            e_wr <= 0; e_done <= 0; e_err <= 0; e_base <= 0;
            e_mask <= 0; e_lanes <= 0;
        end else begin
            // kind: 0 error, 1 open, 2 middle, 3 final, 4 whole
            n = (frm_dlc > 8) ? 8 : int'(frm_dlc);
            hdr = int'(frm_data[7:0]);
            kind = 0; sn = 0; tg = 0;
            if (n != 0) begin
                if (cfg_mode == 0) begin
                    ty = hdr / 64; ct = hdr % 64;
                    if (ty == 0 && ct == 63) kind = 4;
                    else if (ty == 0 && ct == 0) kind = 1;
                    else if ((ty == 1 || ty == 2) && m_open != 0 && ct == m_seq)
                        kind = (ty == 1) ? 2 : 3;
                end else if (cfg_mode == 1) begin
                    sn = hdr % 16;
                    if (hdr / 16 == 2) begin
                        if (m_open == 0 && sn == 1) kind = (n < 8) ? 4 : 1;
                        else if (m_open != 0 && sn == m_seq) kind = (n < 8) ? 3 : 2;
                    end
                end else if (cfg_mode == 2) begin
                    tg = (hdr / 16) % 2;
                    if (tg == ((m_open != 0) ? m_seq : 0)) begin
                        if (m_open != 0) kind = (hdr % 2 == 1) ? 3 : 2;
                        else kind = (hdr % 2 == 1) ? 4 : 1;
                    end
                end
            end
            len  = (n == 0) ? 0 : n - 1;
            base = (kind == 1 || kind == 4) ? 0 : m_fill;
            tot  = base + len;
            if (kind != 0 && tot > 255) kind = 0;
            if ((kind == 3 || kind == 4) && tot == 0) kind = 0;
            lb = '0;
            for (int i = 0; i < 7; i++)
                if (i < len) lb[8*i +: 8] = frm_data[8*(i+1) +: 8];
            if (kind == 0) begin
                e_wr <= 0; e_base <= 0; e_mask <= 0; e_lanes <= 0;
                e_done <= 0; e_err <= 1;
                m_open = 0; m_fill = 0; m_seq = 0;
            end else begin
                e_wr <= (len > 0); e_base <= (len > 0) ? 8'(base) : 8'd0;
                e_mask <= 7'((1 << len) - 1); e_lanes <= lb; e_err <= 0;
                if (kind == 3 || kind == 4) begin
                    e_done <= 1; e_cnt <= 8'(tot);
                    m_open = 0; m_fill = 0; m_seq = 0;
                end else begin
                    e_done <= 0;
                    m_open = 1; m_fill = tot;
                    if (cfg_mode == 0) m_seq = (kind == 1) ? 1 : (m_seq + 1) % 64;
                    else if (cfg_mode == 1) m_seq = (sn + 1) % 16;
                    else m_seq = 1 - tg;
                end
            end
        end
    end

    // cycle-by-cycle comparison against the model (R2 data path, R9 completion, R11 error)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (wr_en !== e_wr || wr_base !== e_base || wr_mask !== e_mask ||
                wr_lanes !== e_lanes || msg_done !== e_done || frag_err !== e_err ||
                done_count !== e_cnt) begin
                fails++;
                $display("FAIL R2/R9/R11 model compare t=%0t: act wr=%b base=%0d mask=%b done=%b err=%b cnt=%0d lanes=%h exp wr=%b base=%0d mask=%b done=%b err=%b cnt=%0d lanes=%h",
                    $time, wr_en, wr_base, wr_mask, msg_done, frag_err, done_count, wr_lanes,
                    e_wr, e_base, e_mask, e_done, e_err, e_cnt, e_lanes);
            end
        end
    end

    function automatic logic [63:0] mk(input logic [7:0] h, input logic [7:0] s);
        logic [63:0] d;
        d[7:0] = h;
        for (int i = 1; i < 8; i++) d[8*i +: 8] = s + 8'(i);
        return d;
    endfunction

    // one frame: drive at a falling edge, check the registered result one cycle later
    task automatic frame(input string tag, input logic [1:0] md, input logic [3:0] dlc,
                         input logic [7:0] h, input logic [7:0] seed,
                         input logic x_done, input logic x_err,
                         input int x_cnt, input int x_base);
        cfg_mode = md; frm_dlc = dlc; frm_data = mk(h, seed); frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        checks++;
        if (msg_done !== x_done || frag_err !== x_err ||
            (x_cnt >= 0 && done_count !== 8'(x_cnt)) ||
            (x_base >= 0 && (wr_base !== 8'(x_base) || wr_en !== 1'b1))) begin
            fails++;
            $display("FAIL %s hdr=%h: act done=%b err=%b cnt=%0d base=%0d wr=%b exp done=%b err=%b cnt=%0d base=%0d",
                     tag, h, msg_done, frag_err, done_count, wr_base, wr_en,
                     x_done, x_err, x_cnt, x_base);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL R1 watchdog: act=hung exp=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (wr_en !== 0 || msg_done !== 0 || frag_err !== 0 || done_count !== 0 ||
            wr_mask !== 0 || wr_base !== 0) begin
            fails++;
            $display("FAIL R12 reset: act wr=%b done=%b err=%b cnt=%0d exp all zero",
                     wr_en, msg_done, frag_err, done_count);
        end
        rst = 1'b0;
        idle(2);

        // R4 R5 mode 0 multi-fragment message: 7+7+4+2 = 20
        frame("R4 open",   2'd0, 4'd8, 8'h00, 8'h10, 0, 0, -1, 0);
        frame("R5 mid1",   2'd0, 4'd8, 8'h41, 8'h20, 0, 0, -1, 7);
        frame("R5 mid2",   2'd0, 4'd5, 8'h42, 8'h30, 0, 0, -1, 14);
        frame("R9 last",   2'd0, 4'd3, 8'h83, 8'h40, 1, 0, 20, 18);
        idle(1);
        frame("R4 whole",  2'd0, 4'd4, 8'h3F, 8'h50, 1, 0, 3, 0);
        // R5 order violations
        frame("R5 mid no open", 2'd0, 4'd8, 8'h41, 8'h00, 0, 1, -1, -1);
        frame("R4 open b",      2'd0, 4'd2, 8'h00, 8'h00, 0, 0, -1, 0);
        frame("R5 skip count",  2'd0, 4'd8, 8'h42, 8'h00, 0, 1, -1, -1);
        frame("R11 last after abort", 2'd0, 4'd8, 8'h81, 8'h00, 0, 1, -1, -1);
        // R6 restart mid message
        frame("R6 open",   2'd0, 4'd8, 8'h00, 8'h60, 0, 0, -1, 0);
        frame("R6 mid",    2'd0, 4'd8, 8'h41, 8'h68, 0, 0, -1, 7);
        frame("R6 reopen", 2'd0, 4'd3, 8'h00, 8'h70, 0, 0, -1, 0);
        frame("R6 last",   2'd0, 4'd2, 8'h81, 8'h78, 1, 0, 3, 2);
        // R4 illegal headers, R9 empty message
        frame("R4 type 11",    2'd0, 4'd8, 8'hC0, 8'h00, 0, 1, -1, -1);
        frame("R4 type 00 cnt5", 2'd0, 4'd8, 8'h05, 8'h00, 0, 1, -1, -1);
        frame("R9 empty whole", 2'd0, 4'd1, 8'h3F, 8'h00, 0, 1, -1, -1);
        idle(2);
        // R10 exact 255 bytes
        frame("R10 open", 2'd0, 4'd8, 8'h00, 8'h01, 0, 0, -1, 0);
        for (int k = 1; k <= 35; k++)
            frame("R10 mid", 2'd0, 4'd8, 8'h40 | 8'(k), 8'(k), 0, 0, -1, 7*k);
        frame("R10 exact 255", 2'd0, 4'd4, 8'hA4, 8'h99, 1, 0, 255, 252);
        // R10 overflow by one
        frame("R10 open2", 2'd0, 4'd8, 8'h00, 8'h01, 0, 0, -1, 0);
        for (int k = 1; k <= 35; k++)
            frame("R10 mid2", 2'd0, 4'd8, 8'h40 | 8'(k), 8'(k), 0, 0, -1, 7*k);
        frame("R10 overflow",  2'd0, 4'd5, 8'h64, 8'h00, 0, 1, -1, -1);
        frame("R11 after overflow", 2'd0, 4'd8, 8'h81, 8'h00, 0, 1, -1, -1);
        // R5 count wraps modulo 64 using empty middle fragments
        frame("R5 wrap open", 2'd0, 4'd1, 8'h00, 8'h00, 0, 0, -1, -1);
        for (int k = 1; k <= 64; k++)
            frame("R5 wrap mid", 2'd0, 4'd1, 8'h40 | 8'(k % 64), 8'h00, 0, 0, -1, -1);
        frame("R5 wrap last", 2'd0, 4'd6, 8'h81, 8'hA0, 1, 0, 5, 0);
        idle(3);

        // R7 mode 1
        frame("R7 sn1", 2'd1, 4'd8, 8'h21, 8'h10, 0, 0, -1, 0);
        frame("R7 sn2", 2'd1, 4'd8, 8'h22, 8'h18, 0, 0, -1, 7);
        frame("R7 short end", 2'd1, 4'd4, 8'h23, 8'h20, 1, 0, 17, 14);
        frame("R7 bad nibble", 2'd1, 4'd8, 8'h31, 8'h00, 0, 1, -1, -1);
        frame("R7 open not sn1", 2'd1, 4'd8, 8'h22, 8'h00, 0, 1, -1, -1);
        for (int k = 1; k <= 17; k++)
            frame("R7 wrap", 2'd1, 4'd8, 8'h20 | 8'(k % 16), 8'(k), 0, 0, -1, 7*(k-1));
        frame("R7 wrap end", 2'd1, 4'd2, 8'h22, 8'h77, 1, 0, 120, 119);
        frame("R7 skip open", 2'd1, 4'd8, 8'h21, 8'h00, 0, 0, -1, 0);
        frame("R7 skip sn",   2'd1, 4'd8, 8'h23, 8'h00, 0, 1, -1, -1);
        idle(1);

        // R8 mode 2
        frame("R8 t0",      2'd2, 4'd8, 8'h00, 8'h30, 0, 0, -1, 0);
        frame("R8 t1",      2'd2, 4'd8, 8'h10, 8'h38, 0, 0, -1, 7);
        frame("R8 t0 last", 2'd2, 4'd5, 8'h01, 8'h40, 1, 0, 18, 14);
        frame("R8 rep open", 2'd2, 4'd8, 8'h00, 8'h00, 0, 0, -1, 0);
        frame("R8 rep t0",   2'd2, 4'd8, 8'h00, 8'h00, 0, 1, -1, -1);
        frame("R8 whole",    2'd2, 4'd8, 8'h01, 8'h50, 1, 0, 7, 0);
        frame("R8 open t1",  2'd2, 4'd8, 8'h10, 8'h00, 0, 1, -1, -1);
        idle(1);

        // R3 reserved mode, R1 DLC edge cases
        frame("R3 reserved", 2'd3, 4'd8, 8'h3F, 8'h00, 0, 1, -1, -1);
        frame("R1 dlc zero", 2'd0, 4'd0, 8'h3F, 8'h00, 0, 1, -1, -1);
        frame("R1 dlc clamp", 2'd0, 4'd12, 8'h3F, 8'h80, 1, 0, 7, 0);
        idle(3);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule